// File: doc/BRIEF.md
# Midpoint Circular Arc Interpolator

The block walks a machine tool along one quarter of a circle in the first quadrant, one grid unit per clock. It travels counter-clockwise: the X coordinate only decreases and the Y coordinate only increases. A one-cycle `go_i` strobe, taken while the block is idle, loads a start point and an end point. The start point is taken to lie on the arc, so the running deviation term `F = x² + y² − r²` is cleared at load and the radius is never needed as an input. From the next cycle on, the block issues one step per clock. Each step is shown by single-cycle pulses on `pulse_x_o` and/or `pulse_y_o`. Stepping stops when the end point is reached. `busy_o` is high while stepping, and the live coordinates and deviation are visible at all times.

Near the X axis the arc is steep (x > y). There Y is the long axis and moves on every step. X moves only when the arc passes to the inner side of the midpoint between the two candidate cells. Near the Y axis the roles swap. Each decision is the sign of one small integer expression built from the current x, y and F, scaled by four so that no fractions appear. It is not a comparison of three candidate distances. The control pins are plain strobes and levels. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `cir_interp`

## Requirements
- R1: While `rst` is high and after it falls, `busy_o`, both pulses, `pos_x_o`, `pos_y_o` and `dev_o` are all zero.
- R2: A `go_i` seen at a rising edge while idle loads the start point into `pos_x_o`/`pos_y_o`, clears `dev_o` to 0 and raises no pulse in that cycle.
- R3: In the steep region (x > y) every step raises `pulse_y_o` and increases Y by 1. It also raises `pulse_x_o` and decreases X by 1 exactly when 4F + 8y − 4x + 5 > 0, evaluated on the values before the step.
- R4: In the flat region (x ≤ y) every step raises `pulse_x_o` and decreases X by 1. It also raises `pulse_y_o` and increases Y by 1 exactly when 4F − 8x + 4y + 5 < 0, evaluated on the values before the step.
- R5: Each step adds −2x+1 to F if X moved and 2y+1 to F if Y moved, using the values before the step. `dev_o` therefore always equals x² + y² − x₀² − y₀². It is a two's-complement signed value.
- R6: While `busy_o` is high the block makes exactly one step per clock. A pulse is high for one cycle only, in the same cycle that the coordinate it names shows its new value. No pulse occurs while idle.
- R7: `busy_o` falls on the step that lands on the end point, or on the step that brings X to 0 if the end point is never met. No pulse follows.
- R8: `go_i` is ignored while `busy_o` is high. The arc in progress finishes at its own end point.
- R9: If the start point equals the end point, or the start X is 0, the load still happens but `busy_o` stays low and no pulse is issued.
- R10: For a start of (r,0) and an end of (0,r), every visited point satisfies |x² + y² − r²| ≤ r. With r = 5 the arc takes exactly 7 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start strobe, honoured only while idle |
| from_x_i | input | CW | Start point X |
| from_y_i | input | CW | Start point Y |
| to_x_i | input | CW | End point X |
| to_y_i | input | CW | End point Y |
| pulse_x_o | output | 1 | One-cycle step on X (X decreases by 1) |
| pulse_y_o | output | 1 | One-cycle step on Y (Y increases by 1) |
| busy_o | output | 1 | High while the arc is being stepped |
| pos_x_o | output | CW | Current X coordinate |
| pos_y_o | output | CW | Current Y coordinate |
| dev_o | output | CW+6 | Signed deviation x² + y² − r² |

## Verification
The bench goes after the point where the regions swap at x = y. There a design that tests the wrong region would stall the long axis or move the wrong coordinate, and the radius bound would break within a few steps. It covers the degenerate arcs: a start equal to the end, a start on the Y axis, and an end that lies off the traced path. A design that mishandled these would raise `busy_o`, step past zero, or never stop. It pulses `go_i` in the middle of an arc, which a design lacking the busy guard would answer by reloading and wandering away from the end point. The full quarter arcs, run over many radii, expose an off-by-one in the deviation update as drift in `dev_o` and a wrong step count.

// File: rtl/cir_pkg.sv
package cir_pkg;

  // Which axis is the long one for the current point.
  typedef enum logic {
    REG_STEEP = 1'b0,  // x > y : Y moves every step
    REG_FLAT  = 1'b1   // x <= y: X moves every step
  } region_e;

  // One step worth of motion.
  typedef struct packed {
    logic dec_x;  // X decreases by one
    logic inc_y;  // Y increases by one
  } move_t;

endpackage

// File: rtl/cir_decide.sv
module cir_decide
  import cir_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = CW + 6
) (
  input  logic [CW-1:0]        x_i,
  input  logic [CW-1:0]        y_i,
  input  logic signed [DW-1:0] f_i,
  output move_t                mv_o
);

  localparam int                 PAD  = DW - CW;
  localparam logic signed [DW-1:0] FIVE = DW'(5);

  logic signed [DW-1:0] xs, ys;
  logic signed [DW-1:0] d_steep, d_flat;
  region_e              rgn;

  always_comb begin
    xs = $signed({{PAD{1'b0}}, x_i});
    ys = $signed({{PAD{1'b0}}, y_i});
    // scaled midpoint test when Y is the long axis
    d_steep = (f_i <<< 2) + (ys <<< 3) - (xs <<< 2) + FIVE;
    // scaled midpoint test when X is the long axis
    d_flat  = (f_i <<< 2) - (xs <<< 3) + (ys <<< 2) + FIVE;
    rgn     = (x_i > y_i) ? REG_STEEP : REG_FLAT;
  end

  // Both tests are 1 mod 4 and never zero, so the sign bit alone decides.
  always_comb begin
    unique case (rgn)
      REG_STEEP: begin
        mv_o.inc_y = 1'b1;
        mv_o.dec_x = ~d_steep[DW-1];
      end
      default: begin
        mv_o.dec_x = 1'b1;
        mv_o.inc_y = d_flat[DW-1];
      end
    endcase
  end

endmodule

// File: rtl/cir_update.sv
module cir_update
  import cir_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = CW + 6
) (
  input  logic [CW-1:0]        x_i,
  input  logic [CW-1:0]        y_i,
  input  logic signed [DW-1:0] f_i,
  input  move_t                mv_i,
  output logic [CW-1:0]        x_o,
  output logic [CW-1:0]        y_o,
  output logic signed [DW-1:0] f_o
);

  localparam int                 PAD = DW - CW;
  localparam logic signed [DW-1:0] ONE = DW'(1);

  logic signed [DW-1:0] xs, ys, tx, ty;

  always_comb begin
    xs = $signed({{PAD{1'b0}}, x_i});
    ys = $signed({{PAD{1'b0}}, y_i});
    tx = mv_i.dec_x ? (ONE - (xs <<< 1)) : '0;
    ty = mv_i.inc_y ? ((ys <<< 1) + ONE) : '0;
    f_o = f_i + tx + ty;
    x_o = x_i - CW'(mv_i.dec_x);
    y_o = y_i + CW'(mv_i.inc_y);
  end

endmodule

// File: rtl/cir_seq.sv
module cir_seq #(
  parameter int CW = 16
) (
  input  logic          go_i,
  input  logic          busy_i,
  input  logic [CW-1:0] from_x_i,
  input  logic [CW-1:0] from_y_i,
  input  logic [CW-1:0] to_x_i,
  input  logic [CW-1:0] to_y_i,
  input  logic [CW-1:0] tgt_x_i,
  input  logic [CW-1:0] tgt_y_i,
  input  logic [CW-1:0] nx_i,
  input  logic [CW-1:0] ny_i,
  output logic          load_o,
  output logic          step_o,
  output logic          busy_d_o
);

  logic arrive, launch;

  always_comb begin
    load_o = go_i & ~busy_i;
    step_o = busy_i;
    // stop on the end point, or when X has nowhere left to go
    arrive = ((nx_i == tgt_x_i) && (ny_i == tgt_y_i)) || (nx_i == '0);
    launch = ((from_x_i != to_x_i) || (from_y_i != to_y_i)) && (from_x_i != '0);
    if (load_o)      busy_d_o = launch;
    else if (step_o) busy_d_o = ~arrive;
    else             busy_d_o = 1'b0;
  end

endmodule

// File: rtl/cir_interp.sv
module cir_interp
  import cir_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [CW-1:0]     from_x_i,
  input  logic [CW-1:0]     from_y_i,
  input  logic [CW-1:0]     to_x_i,
  input  logic [CW-1:0]     to_y_i,
  output logic              pulse_x_o,
  output logic              pulse_y_o,
  output logic              busy_o,
  output logic [CW-1:0]     pos_x_o,
  output logic [CW-1:0]     pos_y_o,
  output logic [CW+5:0]     dev_o
);

  localparam int DW = CW + 6;

  logic [CW-1:0]        x_q, y_q, tgt_x_q, tgt_y_q;
  logic signed [DW-1:0] f_q;
  logic                 busy_q, px_q, py_q;

  move_t                mv;
  logic [CW-1:0]        nx, ny;
  logic signed [DW-1:0] nf;
  logic                 load, step, busy_d;

  cir_decide #(.CW(CW), .DW(DW)) u_decide (
    .x_i  (x_q),
    .y_i  (y_q),
    .f_i  (f_q),
    .mv_o (mv)
  );

  cir_update #(.CW(CW), .DW(DW)) u_update (
    .x_i  (x_q),
    .y_i  (y_q),
    .f_i  (f_q),
    .mv_i (mv),
    .x_o  (nx),
    .y_o  (ny),
    .f_o  (nf)
  );

  cir_seq #(.CW(CW)) u_seq (
    .go_i     (go_i),
    .busy_i   (busy_q),
    .from_x_i (from_x_i),
    .from_y_i (from_y_i),
    .to_x_i   (to_x_i),
    .to_y_i   (to_y_i),
    .tgt_x_i  (tgt_x_q),
    .tgt_y_i  (tgt_y_q),
    .nx_i     (nx),
    .ny_i     (ny),
    .load_o   (load),
    .step_o   (step),
    .busy_d_o (busy_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q     <= '0;
      y_q     <= '0;
      tgt_x_q <= '0;
      tgt_y_q <= '0;
      f_q     <= '0;
      busy_q  <= 1'b0;
      px_q    <= 1'b0;
      py_q    <= 1'b0;
    end else begin
      px_q   <= 1'b0;
      py_q   <= 1'b0;
      busy_q <= busy_d;
      if (load) begin
        x_q     <= from_x_i;
        y_q     <= from_y_i;
        tgt_x_q <= to_x_i;
        tgt_y_q <= to_y_i;
        f_q     <= '0;
      end else if (step) begin
        x_q  <= nx;
        y_q  <= ny;
        f_q  <= nf;
        px_q <= mv.dec_x;
        py_q <= mv.inc_y;
      end
    end
  end

  assign pulse_x_o = px_q;
  assign pulse_y_o = py_q;
  assign busy_o    = busy_q;
  assign pos_x_o   = x_q;
  assign pos_y_o   = y_q;
  assign dev_o     = f_q;

endmodule

// File: rtl/cir_interp_chk.sv
module cir_interp_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          go_i,
  input logic          pulse_x_o,
  input logic          pulse_y_o,
  input logic          busy_o,
  input logic [CW-1:0] pos_x_o,
  input logic [CW-1:0] pos_y_o,
  input logic [CW+5:0] dev_o,
  input logic [CW-1:0] tgt_x_q,
  input logic [CW-1:0] tgt_y_q
);

  AST_PULSE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (pulse_x_o || pulse_y_o) |-> $past(busy_o)); // R6

  AST_STEP_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (pulse_x_o || pulse_y_o)); // R6

  AST_STEEP_LONG_AXIS: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (pos_x_o > pos_y_o)) |=> pulse_y_o); // R3

  AST_FLAT_LONG_AXIS: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (pos_x_o <= pos_y_o)) |=> pulse_x_o); // R4

  AST_Y_MOVES_UP: assert property (@(posedge clk) disable iff (rst)
    pulse_y_o |-> (pos_y_o == $past(pos_y_o) + CW'(1))); // R3

  AST_X_MOVES_DOWN: assert property (@(posedge clk) disable iff (rst)
    pulse_x_o |-> (pos_x_o == $past(pos_x_o) - CW'(1))); // R4

  AST_DEV_Y_ONLY: assert property (@(posedge clk) disable iff (rst)
    (pulse_y_o && !pulse_x_o) |->
      (int'($signed(dev_o)) == int'($signed($past(dev_o))) + 2 * int'($past(pos_y_o)) + 1)); // R5

  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (((pos_x_o == tgt_x_q) && (pos_y_o == tgt_y_q)) || (pos_x_o == '0))); // R7

  AST_LOAD_CLEARS_DEV: assert property (@(posedge clk) disable iff (rst)
    ($past(go_i) && !$past(busy_o) && !(pulse_x_o || pulse_y_o)) |-> (dev_o == '0)); // R2

endmodule

bind cir_interp cir_interp_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .go_i      (go_i),
  .pulse_x_o (pulse_x_o),
  .pulse_y_o (pulse_y_o),
  .busy_o    (busy_o),
  .pos_x_o   (pos_x_o),
  .pos_y_o   (pos_y_o),
  .dev_o     (dev_o),
  .tgt_x_q   (tgt_x_q),
  .tgt_y_q   (tgt_y_q)
);

// File: tb/test_cir_interp.sv
module test_cir_interp;

  localparam int CW = 16;
  localparam int DW = CW + 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst, go;
  logic [CW-1:0] fx, fy, tx, ty;
  logic          pulse_x, pulse_y, busy;
  logic [CW-1:0] pos_x, pos_y;
  logic [DW-1:0] dev;

  cir_interp #(.CW(CW)) i_cir_interp (
    .clk(clk), .rst(rst), .go_i(go),
    .from_x_i(fx), .from_y_i(fy), .to_x_i(tx), .to_y_i(ty),
    .pulse_x_o(pulse_x), .pulse_y_o(pulse_y), .busy_o(busy),
    .pos_x_o(pos_x), .pos_y_o(pos_y), .dev_o(dev)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int m_x, m_y, m_r2, m_tx, m_ty, m_px, m_py;
  bit m_busy;
  bit bound_on = 0;
  int bound_r = 0;
  int step_cnt = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference: midpoint tests written on the true circle through the start point
  always @(posedge clk) begin
    if (rst) begin
      m_x = 0; m_y = 0; m_r2 = 0; m_tx = 0; m_ty = 0;
      m_px = 0; m_py = 0; m_busy = 0;
    end else begin
      m_px = 0; m_py = 0;
      if (m_busy) begin
        if (m_x > m_y) begin
          m_py = 1;
          if ((2*m_x-1)*(2*m_x-1) + 4*(m_y+1)*(m_y+1) - 4*m_r2 > 0) m_px = 1;
        end else begin
          m_px = 1;
          if (4*(m_x-1)*(m_x-1) + (2*m_y+1)*(2*m_y+1) - 4*m_r2 < 0) m_py = 1;
        end
        m_x = m_x - m_px;
        m_y = m_y + m_py;
        if ((m_x == m_tx && m_y == m_ty) || m_x == 0) m_busy = 0;
      end else if (go) begin
        m_x = int'(fx); m_y = int'(fy); m_tx = int'(tx); m_ty = int'(ty);
        m_r2 = m_x*m_x + m_y*m_y;
        m_busy = !(fx == tx && fy == ty) && (fx != 0);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(pulse_x == m_px[0], "R3 R4 pulse_x", pulse_x, m_px);
      check(pulse_y == m_py[0], "R3 R4 pulse_y", pulse_y, m_py);
      check(busy == m_busy, "R7 busy", busy, m_busy);
      check(int'(pos_x) == m_x, "R3 R4 pos_x", pos_x, m_x);
      check(int'(pos_y) == m_y, "R3 R4 pos_y", pos_y, m_y);
      check(int'($signed(dev)) == m_x*m_x + m_y*m_y - m_r2, "R5 dev",
            $signed(dev), m_x*m_x + m_y*m_y - m_r2);
      if (pulse_x || pulse_y) step_cnt++;
      if (bound_on) begin
        int e;
        e = int'(pos_x)*int'(pos_x) + int'(pos_y)*int'(pos_y) - bound_r*bound_r;
        if (e < 0) e = -e;
        check(e <= bound_r, "R10 radius bound", e, bound_r);
      end
    end
  end

  // run one arc; inject > 0 pulses go again that many cycles into the arc
  task automatic run_arc(input int ax, input int ay, input int bx, input int by,
                         input int ex, input int ey, input int exp_steps,
                         input int r_bound, input int inject);
    @(negedge clk);
    fx = CW'(ax); fy = CW'(ay); tx = CW'(bx); ty = CW'(by);
    go = 1'b1; step_cnt = 0;
    @(negedge clk);
    go = 1'b0;
    #1;
    check(int'(pos_x) == ax && int'(pos_y) == ay, "R2 load point", pos_x, ax);
    check(dev == '0, "R2 deviation cleared", $signed(dev), 0);
    check(!pulse_x && !pulse_y, "R2 no pulse on load", {pulse_x, pulse_y}, 0);
    bound_on = (r_bound > 0); bound_r = r_bound;
    for (int k = 0; k < 100000 && busy; k++) begin
      if (inject > 0 && k == inject) begin
        fx = CW'(ax + 3); fy = 0; tx = 1; ty = 1; go = 1'b1;
      end else go = 1'b0;
      @(negedge clk);
      #1;
    end
    go = 1'b0;
    #1;
    bound_on = 0;
    check(!busy, "R7 busy low at end", busy, 0);
    check(int'(pos_x) == ex, "R7 final x", pos_x, ex);
    check(int'(pos_y) == ey, "R7 final y", pos_y, ey);
    if (exp_steps >= 0) check(step_cnt == exp_steps, "R10 step count", step_cnt, exp_steps);
    // no pulse after the end
    @(negedge clk); #1;
    check(!pulse_x && !pulse_y, "R6 R7 quiet after end", {pulse_x, pulse_y}, 0);
  endtask

  initial begin
    rst = 1'b1; go = 1'b0; fx = '0; fy = '0; tx = '0; ty = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !pulse_x && !pulse_y, "R1 reset controls", {busy, pulse_x, pulse_y}, 0);
    check(pos_x == '0 && pos_y == '0, "R1 reset position", {pos_x, pos_y}, 0);
    check(dev == '0, "R1 reset deviation", $signed(dev), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && dev == '0, "R1 idle after reset", busy, 0);

    // R10: radius 5 quarter arc takes 7 steps
    run_arc(5, 0, 0, 5, 0, 5, 7, 5, 0);
    // R3 R4: full quarter arcs over many radii, with region swap at x = y
    for (int r = 1; r <= 40; r++) run_arc(r, 0, 0, r, 0, r, -1, r, 0);
    run_arc(1000, 0, 0, 1000, 0, 1000, -1, 1000, 0);
    // R7: partial arc ending in the steep region
    run_arc(5, 0, 3, 4, 3, 4, 4, 5, 0);
    // R3 R4: start mid-arc in the steep region, crossing the swap point
    run_arc(4, 3, 0, 5, 0, 5, 4, 5, 0);
    // R7: end point off the path, stop when X reaches 0
    run_arc(5, 0, 1, 1, 0, 5, 7, 5, 0);
    // R8: go pulsed mid-arc is ignored
    run_arc(20, 0, 0, 20, 0, 20, -1, 20, 3);
    // R9: start equals end
    run_arc(5, 0, 5, 0, 5, 0, 0, 0, 0);
    check(!busy, "R9 no busy when start equals end", busy, 0);
    // R9: start on the Y axis
    run_arc(0, 5, 0, 7, 0, 5, 0, 0, 0);
    check(!busy, "R9 no busy when start x is 0", busy, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule